// File: doc/BRIEF.md
# Dynamic Local Bus Width Adapter

This block connects a 32-bit host access port to a local peripheral bus whose data width is 8, 16 or 32 bits, chosen by the address region being accessed. A single host access carries a word address and four active-high byte-lane enables. The adapter turns it into as many narrow local cycles as the region width and the enabled lanes need. The low local address bits come from the lane being served, so a narrow peripheral sees a plain linear byte or halfword address space.

On writes, each narrow cycle presents its byte or halfword on the low lanes of the local data bus, and active-low local byte enables mark the bytes that are valid. On reads, each narrow result is moved back to its original lane of the 32-bit host word. Lanes that were not enabled read as zero. Every local cycle has a fixed shape: one setup clock followed by one strobe clock. While a sequence runs the adapter reports busy and ignores new requests. It raises a one-clock ready when the last cycle has finished.

Top module: `lbus_width_adapter`

## Requirements
- R1: The region is the top two bits of the host word address. The region map holds a 2-bit code per region: 0 means 8-bit, 1 means 16-bit, and 2 or 3 means 32-bit. By default region 0 is 8-bit, region 1 is 16-bit, and regions 2 and 3 are 32-bit.
- R2: A 32-bit region access runs one local cycle. Its address has low bits 00 and upper bits equal to the host word address. `loc_lbe_n` is the bitwise inverse of `host_be`, and `loc_wdata` equals `host_wdata`.
- R3: An 8-bit region access runs one cycle per enabled lane, in ascending lane order. Local address bits [1:0] equal the lane number and `loc_lbe_n` is 4'b1110. The byte appears on `loc_wdata[7:0]` with zeros above it.
- R4: A 16-bit region access runs one cycle for each halfword that has an enabled byte, lower halfword first. Address bit 1 is the halfword index and bit 0 is 0. `loc_lbe_n[1:0]` is the inverse of that halfword's two enables and `loc_lbe_n[3:2]` is 11. The halfword appears on `loc_wdata[15:0]`.
- R5: On reads, each narrow result is captured at the end of its strobe clock and placed in its original host lane. Lanes that were not enabled read as zero in `host_rdata`.
- R6: `host_ready` is high for exactly one clock, in the clock after the strobe clock of the last local cycle, with `host_rdata` valid. An access of n local cycles accepted at edge 0 raises ready after edge 2n.
- R7: Each local cycle holds `loc_cyc` high for two clocks. `loc_strb` is low in the first clock and high in the second. Address, enables and write data stay stable across both clocks.
- R8: An access with all four enables low raises `host_ready` in the next clock. It runs no local cycle and `host_busy` stays low.
- R9: `host_busy` is high from the acceptance edge until ready. A `host_req` seen while busy is ignored and starts no local cycle.
- R10: After reset, `host_busy`, `host_ready`, `loc_cyc`, `loc_strb` and `loc_we` are low and `loc_lbe_n` is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, sampled when not busy |
| host_we | input | 1 | 1 = write, 0 = read |
| host_waddr | input | ADDR_W-2 | Host word address |
| host_be | input | 4 | Active-high byte-lane enables |
| host_wdata | input | 32 | Host write data |
| host_busy | output | 1 | Sequence in progress |
| host_ready | output | 1 | One-clock completion pulse |
| host_rdata | output | 32 | Reassembled read data |
| loc_cyc | output | 1 | Local cycle in progress |
| loc_strb | output | 1 | Local strobe (second clock of cycle) |
| loc_we | output | 1 | Local write |
| loc_addr | output | ADDR_W | Local byte address |
| loc_lbe_n | output | 4 | Active-low local byte enables |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data |

## Verification
The bench targets sparse enable patterns in narrow regions, such as alternate bytes in an 8-bit region and a pattern that straddles both halfwords in a 16-bit region. A design that counted cycles by region width rather than by enabled lanes would issue extra cycles there and corrupt neighbouring bytes. A design that took the low address bits from the host would hit the wrong byte. Read-back of partial words shows whether results are steered into the wrong lane or whether disabled lanes leak data. The all-disabled access checks for a hang or a stray local cycle. A request raised mid-sequence checks that a design which does not honour busy would start an overlapping cycle that the bench can see.

// File: rtl/lbwa_pkg.sv
package lbwa_pkg;
  typedef enum logic [1:0] {LW_8 = 2'd0, LW_16 = 2'd1, LW_32 = 2'd2} lw_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SETUP = 2'd1, ST_STRB = 2'd2} st_e;
endpackage

// File: rtl/lbwa_region_dec.sv
module lbwa_region_dec
  import lbwa_pkg::*;
#(
  parameter int WA_W = 8,
  parameter int RGN_BITS = 2,
  parameter logic [2*(1<<RGN_BITS)-1:0] REGION_MAP = 8'b10_10_01_00
) (
  input  logic [WA_W-1:0] waddr,
  output lw_e             width
);
  localparam int NRGN = 1 << RGN_BITS;

  logic [RGN_BITS-1:0] rgn;
  logic [1:0]          code [NRGN];

  assign rgn = waddr[WA_W-1 -: RGN_BITS];

  for (genvar g = 0; g < NRGN; g++) begin : g_code
    assign code[g] = REGION_MAP[2*g +: 2];
  end

  always_comb begin
    case (code[rgn])
      2'd0:    width = LW_8;
      2'd1:    width = LW_16;
      default: width = LW_32;
    endcase
  end
endmodule

// File: rtl/lbwa_unit_seq.sv
module lbwa_unit_seq
  import lbwa_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  lw_e              width,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] mask,
  input  logic [LANES-1:0] pend,
  output logic [IDX_W-1:0] first,
  output logic             any
);
  localparam int HALVES = LANES / 2;

  logic [HALVES-1:0] half_any;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_any[h] = |be[2*h +: 2];
  end

  always_comb begin
    mask = '0;
    case (width)
      LW_8:    mask = be;
      LW_16:   mask[HALVES-1:0] = half_any;
      default: mask[0] = |be;
    endcase
  end

  always_comb begin
    first = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) first = IDX_W'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/lbwa_lane_map.sv
module lbwa_lane_map
  import lbwa_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input  lw_e              width,
  input  logic [IDX_W-1:0] unit,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] addr_lo,
  output logic [LANES-1:0] lbe_n,
  output logic [DW-1:0]    lwdata
);
  always_comb begin
    addr_lo = '0;
    lbe_n   = '1;
    lwdata  = '0;
    case (width)
      LW_8: begin
        addr_lo     = unit;
        lbe_n[0]    = 1'b0;
        lwdata[7:0] = wdata[unit*8 +: 8];
      end
      LW_16: begin
        addr_lo      = {unit[IDX_W-2:0], 1'b0};
        lbe_n[1:0]   = ~be[unit[IDX_W-2:0]*2 +: 2];
        lwdata[15:0] = wdata[unit[IDX_W-2:0]*16 +: 16];
      end
      default: begin
        lbe_n  = ~be;
        lwdata = wdata;
      end
    endcase
  end
endmodule

// File: rtl/lbwa_rd_steer.sv
module lbwa_rd_steer
  import lbwa_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input  lw_e              width,
  input  logic [IDX_W-1:0] unit,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    ldata,
  input  logic [DW-1:0]    acc,
  output logic [DW-1:0]    nxt
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_IX = IDX_W'(i);
    localparam logic [IDX_W-1:0] HALF_IX = IDX_W'(i / 2);
    logic       take;
    logic [7:0] src;

    always_comb begin
      case (width)
        LW_8: begin
          take = (unit == LANE_IX);
          src  = ldata[7:0];
        end
        LW_16: begin
          take = (unit == HALF_IX);
          src  = ldata[(i%2)*8 +: 8];
        end
        default: begin
          take = 1'b1;
          src  = ldata[i*8 +: 8];
        end
      endcase
    end

    assign nxt[i*8 +: 8] = (take && be[i]) ? src : acc[i*8 +: 8];
  end
endmodule

// File: rtl/lbus_width_adapter.sv
module lbus_width_adapter
  import lbwa_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES = 4,
  parameter int RGN_BITS = 2,
  parameter logic [2*(1<<RGN_BITS)-1:0] REGION_MAP = 8'b10_10_01_00,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_req,
  input  logic                    host_we,
  input  logic [ADDR_W-IDX_W-1:0] host_waddr,
  input  logic [LANES-1:0]        host_be,
  input  logic [8*LANES-1:0]      host_wdata,
  output logic                    host_busy,
  output logic                    host_ready,
  output logic [8*LANES-1:0]      host_rdata,
  output logic                    loc_cyc,
  output logic                    loc_strb,
  output logic                    loc_we,
  output logic [ADDR_W-1:0]       loc_addr,
  output logic [LANES-1:0]        loc_lbe_n,
  output logic [8*LANES-1:0]      loc_wdata,
  input  logic [8*LANES-1:0]      loc_rdata
);
  localparam int DW   = 8 * LANES;
  localparam int WA_W = ADDR_W - IDX_W;

  st_e              st;
  logic             r_we;
  logic [WA_W-1:0]  r_waddr;
  logic [LANES-1:0] r_be;
  logic [DW-1:0]    r_wdata;
  lw_e              r_width;
  logic [LANES-1:0] pend;
  logic [IDX_W-1:0] cur;
  logic [DW-1:0]    acc;

  lw_e              dec_width;
  logic [LANES-1:0] mask_host;
  logic [LANES-1:0] pend_clr;
  logic [LANES-1:0] prio_in;
  logic [IDX_W-1:0] first;
  logic             first_any;
  lw_e              sel_width;
  logic [LANES-1:0] sel_be;
  logic [DW-1:0]    sel_wdata;
  logic [WA_W-1:0]  sel_waddr;
  logic             sel_we;
  logic [IDX_W-1:0] map_lo;
  logic [LANES-1:0] map_lbe_n;
  logic [DW-1:0]    map_wdata;
  logic [DW-1:0]    acc_nxt;
  logic             in_idle;

  assign in_idle = (st == ST_IDLE);

  lbwa_region_dec #(
    .WA_W(WA_W), .RGN_BITS(RGN_BITS), .REGION_MAP(REGION_MAP)
  ) u_dec (
    .waddr(host_waddr), .width(dec_width)
  );

  assign pend_clr  = pend & ~(LANES'(1) << cur);
  assign prio_in   = in_idle ? mask_host : pend_clr;
  assign sel_width = in_idle ? dec_width : r_width;
  assign sel_be    = in_idle ? host_be : r_be;
  assign sel_wdata = in_idle ? host_wdata : r_wdata;
  assign sel_waddr = in_idle ? host_waddr : r_waddr;
  assign sel_we    = in_idle ? host_we : r_we;

  lbwa_unit_seq #(.LANES(LANES)) u_seq (
    .width(dec_width), .be(host_be), .mask(mask_host),
    .pend(prio_in), .first(first), .any(first_any)
  );

  lbwa_lane_map #(.LANES(LANES)) u_map (
    .width(sel_width), .unit(first), .be(sel_be), .wdata(sel_wdata),
    .addr_lo(map_lo), .lbe_n(map_lbe_n), .lwdata(map_wdata)
  );

  lbwa_rd_steer #(.LANES(LANES)) u_steer (
    .width(r_width), .unit(cur), .be(r_be), .ldata(loc_rdata),
    .acc(acc), .nxt(acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      r_we       <= 1'b0;
      r_waddr    <= '0;
      r_be       <= '0;
      r_wdata    <= '0;
      r_width    <= LW_32;
      pend       <= '0;
      cur        <= '0;
      acc        <= '0;
      host_busy  <= 1'b0;
      host_ready <= 1'b0;
      host_rdata <= '0;
      loc_cyc    <= 1'b0;
      loc_strb   <= 1'b0;
      loc_we     <= 1'b0;
      loc_addr   <= '0;
      loc_lbe_n  <= '1;
      loc_wdata  <= '0;
    end else begin
      host_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (host_req) begin
            r_we    <= host_we;
            r_waddr <= host_waddr;
            r_be    <= host_be;
            r_wdata <= host_wdata;
            r_width <= dec_width;
            acc     <= '0;
            if (!first_any) begin
              host_ready <= 1'b1;
              host_rdata <= '0;
            end else begin
              pend      <= mask_host;
              cur       <= first;
              loc_cyc   <= 1'b1;
              loc_we    <= sel_we;
              loc_addr  <= {sel_waddr, map_lo};
              loc_lbe_n <= map_lbe_n;
              loc_wdata <= map_wdata;
              host_busy <= 1'b1;
              st        <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          loc_strb <= 1'b1;
          st       <= ST_STRB;
        end
        default: begin
          loc_strb <= 1'b0;
          pend     <= pend_clr;
          if (!r_we) acc <= acc_nxt;
          if (first_any) begin
            cur       <= first;
            loc_addr  <= {sel_waddr, map_lo};
            loc_lbe_n <= map_lbe_n;
            loc_wdata <= map_wdata;
            st        <= ST_SETUP;
          end else begin
            loc_cyc    <= 1'b0;
            loc_we     <= 1'b0;
            loc_lbe_n  <= '1;
            host_busy  <= 1'b0;
            host_ready <= 1'b1;
            host_rdata <= r_we ? '0 : acc_nxt;
            st         <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R7: strobe only rises after a setup clock of the same cycle
  assert_setup_before_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(loc_strb) |-> ($past(loc_cyc) && !$past(loc_strb)));

  // R7: strobe lasts exactly one clock
  assert_strobe_one_clock_R7: assert property (@(posedge clk) disable iff (rst)
    loc_strb |=> !loc_strb);

  // R7: address and enables hold from setup into strobe
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
    loc_strb |-> ($stable(loc_addr) && $stable(loc_lbe_n)));

  // R2: every local cycle enables at least one lane
  assert_lane_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    loc_cyc |-> (loc_lbe_n != '1));

  // R6: ready only when the local bus is idle and not busy
  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (!host_busy && !loc_cyc));

  // R6: ready is a single-clock pulse
  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  // R9: local cycles only run while busy
  assert_cyc_needs_busy_R9: assert property (@(posedge clk) disable iff (rst)
    loc_cyc |-> host_busy);
endmodule

// File: tb/lbus_width_adapter_bench.sv
`timescale 1ns/1ps
module lbus_width_adapter_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_req, host_we;
  logic [7:0]  host_waddr;
  logic [3:0]  host_be;
  logic [31:0] host_wdata;
  logic        host_busy, host_ready;
  logic [31:0] host_rdata;
  logic        loc_cyc, loc_strb, loc_we;
  logic [9:0]  loc_addr;
  logic [3:0]  loc_lbe_n;
  logic [31:0] loc_wdata;
  logic [31:0] loc_rdata;

  int total = 0;
  int bad = 0;

  logic [7:0]  mem [1024];
  logic [9:0]  log_addr [16];
  logic [3:0]  log_lbe [16];
  logic [31:0] log_wd [16];
  int nlog = 0;

  always #2.5 clk = ~clk;

  lbus_width_adapter u_lbus_width_adapter (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_waddr(host_waddr),
    .host_be(host_be), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_ready(host_ready), .host_rdata(host_rdata),
    .loc_cyc(loc_cyc), .loc_strb(loc_strb), .loc_we(loc_we),
    .loc_addr(loc_addr), .loc_lbe_n(loc_lbe_n), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata)
  );

  // peripheral model: byte memory, lane i lives at loc_addr + i
  always_comb begin
    for (int i = 0; i < 4; i++)
      loc_rdata[i*8 +: 8] = mem[(int'(loc_addr) + i) % 1024];
  end

  always @(negedge clk) begin
    if (loc_cyc && loc_strb) begin
      if (nlog < 16) begin
        log_addr[nlog] = loc_addr;
        log_lbe[nlog]  = loc_lbe_n;
        log_wd[nlog]   = loc_wdata;
      end
      nlog = nlog + 1;
      if (loc_we)
        for (int i = 0; i < 4; i++)
          if (!loc_lbe_n[i]) mem[(int'(loc_addr) + i) % 1024] = loc_wdata[i*8 +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [9:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int lat, output logic b1);
    @(negedge clk);
    nlog = 0;
    host_req = 1'b1; host_we = we; host_waddr = a[9:2]; host_be = be; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    b1 = host_busy;
    lat = 1;
    while (!host_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = host_rdata;
  endtask

  task automatic t_reset;
    chk("R10 busy", 32'(host_busy), 0);
    chk("R10 ready", 32'(host_ready), 0);
    chk("R10 cyc/strb/we", {29'd0, loc_cyc, loc_strb, loc_we}, 0);
    chk("R10 lbe_n", 32'(loc_lbe_n), 32'hF);
  endtask

  task automatic t_word32;
    logic [31:0] rd; int lat; logic b1;
    access(1'b1, 10'h200, 4'hF, 32'hA1B2C3D4, rd, lat, b1);
    chk("R2 R1 cycles", 32'(nlog), 1);
    chk("R6 latency", 32'(lat), 3);
    chk("R2 addr", 32'(log_addr[0]), 32'h200);
    chk("R2 lbe", 32'(log_lbe[0]), 0);
    chk("R2 wdata", log_wd[0], 32'hA1B2C3D4);
    @(negedge clk);
    chk("R6 pulse", 32'(host_ready), 0);
    access(1'b0, 10'h200, 4'hF, 32'h0, rd, lat, b1);
    chk("R5 read32", rd, 32'hA1B2C3D4);
    access(1'b0, 10'h200, 4'b0101, 32'h0, rd, lat, b1);
    chk("R5 partial32", rd, 32'h00B200D4);
    chk("R2 partial lbe", 32'(log_lbe[0]), 32'hA);
  endtask

  task automatic t_byte8;
    logic [31:0] rd; int lat; logic b1;
    access(1'b1, 10'h010, 4'hF, 32'h11223344, rd, lat, b1);
    chk("R3 R1 cycles", 32'(nlog), 4);
    chk("R6 latency8", 32'(lat), 9);
    for (int k = 0; k < 4; k++) begin
      chk("R3 addr", 32'(log_addr[k]), 32'h010 + 32'(k));
      chk("R3 lbe", 32'(log_lbe[k]), 32'hE);
    end
    chk("R3 wd0", log_wd[0], 32'h44);
    chk("R3 wd3", log_wd[3], 32'h11);
    access(1'b0, 10'h010, 4'hF, 32'h0, rd, lat, b1);
    chk("R5 read8", rd, 32'h11223344);
    access(1'b1, 10'h010, 4'b1010, 32'hAA00BB00, rd, lat, b1);
    chk("R3 sparse cycles", 32'(nlog), 2);
    chk("R3 sparse addr0", 32'(log_addr[0]), 32'h011);
    chk("R3 sparse addr1", 32'(log_addr[1]), 32'h013);
    chk("R3 sparse wd0", log_wd[0], 32'hBB);
    chk("R6 sparse latency", 32'(lat), 5);
    access(1'b0, 10'h010, 4'hF, 32'h0, rd, lat, b1);
    chk("R3 R5 merged", rd, 32'hAA22BB44);
  endtask

  task automatic t_half16;
    logic [31:0] rd; int lat; logic b1;
    access(1'b1, 10'h104, 4'hF, 32'hCAFEBEEF, rd, lat, b1);
    chk("R4 R1 cycles", 32'(nlog), 2);
    chk("R4 addr0", 32'(log_addr[0]), 32'h104);
    chk("R4 addr1", 32'(log_addr[1]), 32'h106);
    chk("R4 lbe", 32'(log_lbe[1]), 32'hC);
    chk("R4 wd0", log_wd[0], 32'hBEEF);
    chk("R4 wd1", log_wd[1], 32'hCAFE);
    access(1'b1, 10'h104, 4'b0110, 32'h77665544, rd, lat, b1);
    chk("R4 straddle lbe0", 32'(log_lbe[0]), 32'hD);
    chk("R4 straddle lbe1", 32'(log_lbe[1]), 32'hE);
    chk("R4 straddle wd0", log_wd[0], 32'h5544);
    access(1'b0, 10'h104, 4'hF, 32'h0, rd, lat, b1);
    chk("R4 R5 read16", rd, 32'hCA6655EF);
    access(1'b0, 10'h104, 4'b1000, 32'h0, rd, lat, b1);
    chk("R4 single cycles", 32'(nlog), 1);
    chk("R4 single addr", 32'(log_addr[0]), 32'h106);
    chk("R4 single lbe", 32'(log_lbe[0]), 32'hD);
    chk("R5 upper lane", rd, 32'hCA000000);
  endtask

  task automatic t_empty;
    logic [31:0] rd; int lat; logic b1;
    access(1'b1, 10'h010, 4'h0, 32'hFFFFFFFF, rd, lat, b1);
    chk("R8 latency", 32'(lat), 1);
    chk("R8 no cycle", 32'(nlog), 0);
    chk("R8 not busy", 32'(b1), 0);
    access(1'b0, 10'h010, 4'hF, 32'h0, rd, lat, b1);
    chk("R8 memory intact", rd, 32'hAA22BB44);
  endtask

  task automatic t_busy;
    logic [31:0] rd; int lat;
    @(negedge clk);
    nlog = 0;
    host_req = 1'b1; host_we = 1'b1; host_waddr = 8'h08; host_be = 4'hF;
    host_wdata = 32'h01020304;
    @(negedge clk);
    host_req = 1'b0;
    chk("R9 busy", 32'(host_busy), 1);
    @(negedge clk);
    host_req = 1'b1; host_waddr = 8'h0C; host_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    host_req = 1'b0;
    lat = 0;
    while (!host_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    repeat (6) @(negedge clk);
    chk("R9 cycles", 32'(nlog), 4);
    chk("R9 idle", 32'(host_busy), 0);
    begin
      int l2; logic b2;
      access(1'b0, 10'h030, 4'hF, 32'h0, rd, l2, b2);
    end
    chk("R9 ignored write", rd, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    rst = 1'b1; host_req = 1'b0; host_we = 1'b0; host_waddr = '0;
    host_be = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_word32;
    t_byte8;
    t_half16;
    t_empty;
    t_busy;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule